// File: doc/BRIEF.md
# Indirect PHY Register Bridge

This block lets a host reach a small byte-wide PHY configuration register file that is not mapped into the host address space. The host sees two 16-bit registers. One is a data register whose low byte holds the byte to send or the byte just returned. The other is a command register that takes a PHY register offset, a direction flag and, when read back, a busy indication.

To write a PHY register, the host loads the data register and then writes the command register with the direction flag set. To read one, the host writes the command register with the flag clear, polls until busy drops, and then reads the data register. On the PHY side the bridge holds a request until the PHY answers with ready, so the PHY may take any number of cycles. Command writes that arrive while a transfer is pending are dropped.

Top module: `phyb_bridge`

## Requirements
- R1: After a synchronous active-high reset the command register reads 0x0000, the data register reads 0x0000 and phy_req is low.
- R2: The command register is at host address 0x300. On a write, bits [7:0] give the PHY offset and bit 8 gives the direction (1 = write, 0 = read). A command write while idle raises phy_req in the next cycle, with phy_offset and phy_we taken from that write.
- R3: Busy, which reads as bit 9 of the command register, and phy_req stay high and phy_offset and phy_we stay steady until the cycle after a cycle with both phy_req and phy_ready high. Any PHY latency of zero or more cycles is accepted.
- R4: In a write transfer, phy_wdata carries the low byte of the data register, and the data register keeps that value after the transfer.
- R5: In a read transfer, phy_rdata is loaded into the data register low byte at the same clock edge that clears busy.
- R6: The data register is at host address 0x304. Bits [15:8] always read as zero, and those bits of a host write are discarded.
- R7: A command write while busy is set is ignored: it starts no second transfer and leaves the offset and direction unchanged.
- R8: A data register write while busy is set is ignored.
- R9: Reading the command register returns the offset last accepted in bits [7:0], its direction in bit 8, busy in bit 9, and zero above.
- R10: Host writes to any other address have no effect, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 12 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| phy_req | output | 1 | Transfer request to the PHY register file |
| phy_we | output | 1 | Direction of the pending transfer, 1 = write |
| phy_offset | output | 8 | PHY register offset |
| phy_wdata | output | 8 | Byte to be written to the PHY |
| phy_rdata | input | 8 | Byte returned by the PHY |
| phy_ready | input | 1 | PHY completes the transfer in this cycle |

## Verification
The assertions assume that the PHY raises phy_ready only while phy_req is high, and that phy_rdata is valid in the cycle where the two are high together. The PHY model in the bench answers only pending requests. Its ready pulse lasts one cycle and comes after a latency that each test sets, from zero to five cycles. The host side gives single-cycle write strobes aligned to the clock, and it sends its conflicting command and data writes only while a transfer is known to be pending.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

    localparam int HOST_AW = 12;
    localparam int HOST_DW = 16;
    localparam int PHY_AW  = 8;
    localparam int PHY_DW  = 8;
    localparam int DIR_BIT  = PHY_AW;
    localparam int BUSY_BIT = PHY_AW + 1;

    typedef struct packed {
        logic              wr;
        logic [PHY_AW-1:0] off;
    } phyb_cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    function automatic phyb_cmd_t unpack_cmd(input logic [HOST_DW-1:0] w);
        phyb_cmd_t c;
        c.wr  = w[DIR_BIT];
        c.off = w[PHY_AW-1:0];
        return c;
    endfunction

    function automatic logic [HOST_DW-1:0] pack_cmd(input phyb_cmd_t c, input logic busy);
        logic [HOST_DW-1:0] r;
        r               = '0;
        r[PHY_AW-1:0]   = c.off;
        r[DIR_BIT]      = c.wr;
        r[BUSY_BIT]     = busy;
        return r;
    endfunction

endpackage

// File: rtl/phyb_decode.sv
module phyb_decode
    import phyb_pkg::*;
#(
    parameter logic [HOST_AW-1:0] CMD_ADDR  = 12'h300,
    parameter logic [HOST_AW-1:0] DATA_ADDR = 12'h304
) (
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    output reg_sel_e           sel,
    output logic               cmd_wr,
    output logic               data_wr
);

    always_comb begin
        if (host_addr == CMD_ADDR)
            sel = SEL_CMD;
        else if (host_addr == DATA_ADDR)
            sel = SEL_DATA;
        else
            sel = SEL_NONE;
    end

    assign cmd_wr  = host_we && (sel == SEL_CMD);
    assign data_wr = host_we && (sel == SEL_DATA);

endmodule

// File: rtl/phyb_seq.sv
module phyb_seq
    import phyb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  phyb_cmd_t cmd_in,
    input  logic      phy_ready,
    output phyb_cmd_t cmd_q,
    output logic      busy,
    output logic      phy_req,
    output logic      done
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cmd_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd_in;
                        state_q <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (phy_ready)
                        state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == SEQ_WAIT);
    assign phy_req = busy;
    assign done    = busy && phy_ready;

    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (phy_req && cmd_q == $past(cmd_in)));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ready) |=> (phy_req && $stable(cmd_q)));

    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ready) |=> !phy_req);

    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !phy_ready) |=> $stable(cmd_q));

endmodule

// File: rtl/phyb_datareg.sv
module phyb_datareg
    import phyb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PHY_DW-1:0] wr_byte,
    input  logic              cap_en,
    input  logic [PHY_DW-1:0] cap_byte,
    output logic [PHY_DW-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (cap_en)
            data_q <= cap_byte;
        else if (wr_en)
            data_q <= wr_byte;
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (data_q == $past(cap_byte)));

    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !cap_en) |=> $stable(data_q));

endmodule

// File: rtl/phyb_bridge.sv
module phyb_bridge
    import phyb_pkg::*;
#(
    parameter logic [HOST_AW-1:0] CMD_ADDR  = 12'h300,
    parameter logic [HOST_AW-1:0] DATA_ADDR = 12'h304
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PHY_AW-1:0]  phy_offset,
    output logic [PHY_DW-1:0]  phy_wdata,
    input  logic [PHY_DW-1:0]  phy_rdata,
    input  logic               phy_ready
);

    reg_sel_e          sel;
    logic              cmd_wr;
    logic              data_wr;
    logic              busy;
    logic              done;
    phyb_cmd_t         cmd_q;
    logic [PHY_DW-1:0] data_q;
    logic              unused_hi;

    assign unused_hi = ^host_wdata[HOST_DW-1:BUSY_BIT];

    phyb_decode #(
        .CMD_ADDR  (CMD_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_decode (
        .host_we   (host_we),
        .host_addr (host_addr),
        .sel       (sel),
        .cmd_wr    (cmd_wr),
        .data_wr   (data_wr)
    );

    phyb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_wr),
        .cmd_in    (unpack_cmd(host_wdata)),
        .phy_ready (phy_ready),
        .cmd_q     (cmd_q),
        .busy      (busy),
        .phy_req   (phy_req),
        .done      (done)
    );

    phyb_datareg u_data (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (data_wr && !busy),
        .wr_byte  (host_wdata[PHY_DW-1:0]),
        .cap_en   (done && !cmd_q.wr),
        .cap_byte (phy_rdata),
        .data_q   (data_q)
    );

    assign phy_we     = cmd_q.wr;
    assign phy_offset = cmd_q.off;
    assign phy_wdata  = data_q;

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            SEL_CMD:  host_rdata = pack_cmd(cmd_q, busy);
            SEL_DATA: host_rdata[PHY_DW-1:0] = data_q;
            default:  host_rdata = '0;
        endcase
    end

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (host_addr == DATA_ADDR) |-> (host_rdata[HOST_DW-1:PHY_DW] == '0));

    a_r10_other_zero: assert property (@(posedge clk) disable iff (rst)
        (host_addr != DATA_ADDR && host_addr != CMD_ADDR) |-> (host_rdata == '0));

    a_r4_wdata_steady: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_we && !phy_ready) |=> $stable(phy_wdata));

endmodule

// File: tb/phyb_bridge_tb.sv
module phyb_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CMD  = 12'h300;
    localparam logic [11:0] A_DATA = 12'h304;

    typedef struct packed {
        logic       we;
        logic [7:0] off;
        logic [7:0] dat;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        phy_req;
    logic        phy_we;
    logic [7:0]  phy_offset;
    logic [7:0]  phy_wdata;
    logic [7:0]  phy_rdata;
    logic        phy_ready;

    int n_chk = 0;
    int n_fail = 0;
    int n_seen = 0;
    int lat = 0;
    int cnt = 0;
    logic [7:0] phy_mem [256];
    logic [7:0] shadow [256];
    xfer_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phyb_bridge u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .phy_req    (phy_req),
        .phy_we     (phy_we),
        .phy_offset (phy_offset),
        .phy_wdata  (phy_wdata),
        .phy_rdata  (phy_rdata),
        .phy_ready  (phy_ready)
    );

    // PHY register file model with a latency chosen per test
    assign phy_rdata = phy_mem[phy_offset];

    always @(posedge clk) begin
        if (rst) begin
            phy_ready <= 1'b0;
            cnt <= 0;
            for (int i = 0; i < 256; i++) phy_mem[i] <= 8'(i) ^ 8'h5A;
        end else if (phy_req && !phy_ready) begin
            if (cnt >= lat) phy_ready <= 1'b1;
            else cnt <= cnt + 1;
        end else begin
            if (phy_req && phy_ready && phy_we) phy_mem[phy_offset] <= phy_wdata;
            phy_ready <= 1'b0;
            cnt <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every completed PHY transfer
    always @(negedge clk) begin
        if (!rst && phy_req && phy_ready) begin
            xfer_t e;
            n_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected transfer", {7'd0, phy_we, phy_offset}, 16'h0);
            end else begin
                e = exp_q.pop_front();
                check(phy_we == e.we && phy_offset == e.off, "R2 transfer offset/dir",
                      {7'd0, phy_we, phy_offset}, {7'd0, e.we, e.off});
                if (e.we)
                    check(phy_wdata == e.dat, "R4 phy_wdata", {8'd0, phy_wdata}, {8'd0, e.dat});
            end
        end
    end

    task automatic host_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [15:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int k = 0; k < 100; k++) begin
            host_read(A_CMD, v);
            if (!v[9]) return;
            @(negedge clk);
        end
        check(1'b0, "R3 busy never cleared", 16'h0200, 16'h0000);
    endtask

    task automatic phy_wr(input logic [7:0] off, input logic [7:0] d);
        host_write(A_DATA, {8'h00, d});
        exp_q.push_back('{we: 1'b1, off: off, dat: d});
        shadow[off] = d;
        host_write(A_CMD, {7'd0, 1'b1, off});
    endtask

    task automatic phy_rd(input logic [7:0] off);
        exp_q.push_back('{we: 1'b0, off: off, dat: 8'h00});
        host_write(A_CMD, {7'd0, 1'b0, off});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        host_read(A_CMD, v);  check(v == 16'h0000, "R1 cmd after reset", v, 16'h0000);
        host_read(A_DATA, v); check(v == 16'h0000, "R1 data after reset", v, 16'h0000);
        check(phy_req == 1'b0, "R1 phy_req after reset", {15'd0, phy_req}, 16'h0);

        // R6: upper data bits discarded
        host_write(A_DATA, 16'hF1A5);
        host_read(A_DATA, v); check(v == 16'h00A5, "R6 data upper bits", v, 16'h00A5);

        // R2/R4/R9: write transfer with latency 2
        lat = 2;
        exp_q.push_back('{we: 1'b1, off: 8'h21, dat: 8'hA5});
        shadow[8'h21] = 8'hA5;
        host_write(A_CMD, 16'h0121);
        host_read(A_CMD, v); check(v == 16'h0321, "R9 busy readback", v, 16'h0321);
        check(phy_req && phy_we && phy_offset == 8'h21, "R2 launch",
              {phy_req, 6'd0, phy_we, phy_offset}, 16'h8121);
        wait_idle();
        host_read(A_CMD, v);  check(v == 16'h0121, "R9 idle readback", v, 16'h0121);
        host_read(A_DATA, v); check(v == 16'h00A5, "R4 data kept", v, 16'h00A5);

        // R3/R5: read transfer with latency 4
        lat = 4;
        phy_rd(8'h0C);
        repeat (3) @(negedge clk);
        host_read(A_CMD, v); check(v[9] == 1'b1, "R3 busy held", v, 16'h020C);
        wait_idle();
        host_read(A_DATA, v);
        check(v == {8'h00, shadow[8'h0C]}, "R5 read data at busy clear", v, {8'h00, shadow[8'h0C]});

        // R7: command write during busy is dropped
        lat = 5;
        phy_rd(8'h40);
        host_write(A_CMD, 16'h0155);
        host_read(A_CMD, v); check(v == 16'h0240, "R7 cmd unchanged", v, 16'h0240);
        wait_idle();
        check(n_seen == 3 && exp_q.size() == 0, "R7 one transfer only", 16'(n_seen), 16'd3);
        host_read(A_DATA, v); check(v == {8'h00, shadow[8'h40]}, "R5 read 0x40", v, {8'h00, shadow[8'h40]});

        // R8: data write during busy is dropped (read and write transfers)
        phy_rd(8'h12);
        host_write(A_DATA, 16'h0033);
        wait_idle();
        host_read(A_DATA, v); check(v == {8'h00, shadow[8'h12]}, "R8 data during read", v, {8'h00, shadow[8'h12]});
        phy_wr(8'h30, 8'h44);
        host_write(A_DATA, 16'h0066);
        wait_idle();
        host_read(A_DATA, v); check(v == 16'h0044, "R8 data during write", v, 16'h0044);
        phy_rd(8'h30);
        wait_idle();
        host_read(A_DATA, v); check(v == 16'h0044, "R4 PHY holds written byte", v, 16'h0044);

        // R10: other address
        host_write(12'h308, 16'hFFFF);
        host_read(12'h308, v); check(v == 16'h0000, "R10 other read", v, 16'h0000);
        host_read(A_CMD, v);   check(v == 16'h0030, "R10 cmd unchanged", v, 16'h0030);
        host_read(A_DATA, v);  check(v == 16'h0044, "R10 data unchanged", v, 16'h0044);
        check(phy_req == 1'b0, "R10 no transfer", {15'd0, phy_req}, 16'h0);

        // R3/R5: zero latency, several offsets
        lat = 0;
        for (int j = 0; j < 4; j++) begin
            logic [7:0] o;
            o = 8'(8'h80 + j * 8'h11);
            phy_rd(o);
            wait_idle();
            host_read(A_DATA, v);
            check(v == {8'h00, shadow[o]}, "R5 zero latency read", v, {8'h00, shadow[o]});
        end
        phy_wr(8'hFE, 8'h3C);
        wait_idle();
        phy_rd(8'hFE);
        wait_idle();
        host_read(A_DATA, v); check(v == 16'h003C, "R4 zero latency write", v, 16'h003C);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", 16'(exp_q.size()), 16'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule